// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a clock-generating serial port. It drives a shift clock and captures one data bit on each falling edge of that clock, least significant bit first, into a shift register. Software asks for a single character with a self-clearing request bit, or for a continuous stream with a level control bit. Each finished 8-bit character drops into a two-entry FIFO, which software drains through a read strobe and a read-data port.

If a character completes while the FIFO is full, the block does not overwrite anything. It raises an overrun flag and stops clocking. How that flag clears depends on the mode that was active when the overrun happened. Dropping the port enable returns the whole receiver to its idle state.

Top module: `sync_master_rx`

## Requirements
- R1: The shift clock idles low. Once running, each clock level lasts `half_div` system clocks, and a value of 0 is treated as 1. A single request with `cont_en` low yields exactly 8 rising edges and then the clock stops.
- R2: `single_req` is set by a `single_set` pulse and clears by itself in the cycle after the character's eighth falling edge.
- R3: While `cont_en` is high, characters follow one another with no gap in the clock.
- R4: Dropping `cont_en` partway through a character forces the clock low on the next cycle. The partial character is discarded, and the next character starts again from bit 0.
- R5: With both requests active, `single_req` clears after the first character and clocking continues under continuous mode.
- R6: `sdata_in` is sampled on each falling shift-clock edge, least significant bit first. The completed character is in the FIFO, with `rx_pending` high, one cycle after the eighth falling edge.
- R7: `rd_data` shows the oldest unread character. Each cycle with `rd_strobe` high removes one entry. `rx_pending` is high exactly while entries remain.
- R8: A read strobe while the FIFO is empty leaves `rd_data` at the last character read and changes nothing else.
- R9: A character that completes while two entries are held, with no read in that same cycle, sets `overrun`. The stored entries are kept, and no clock runs while `overrun` is high.
- R10: An overrun raised with `cont_en` low clears on the cycle after a read strobe, and that read also removes one entry.
- R11: An overrun raised with `cont_en` high ignores reads. It clears on the cycle after `cont_en` goes low.
- R12: While `port_en` is low the FIFO empties, all flags clear, `rd_data` reads 0, the clock stays low and `single_set` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low holds the receiver in reset |
| single_set | input | 1 | Pulse that requests one character |
| cont_en | input | 1 | Continuous receive request (level) |
| half_div | input | 8 | System clocks per shift-clock level (0 acts as 1) |
| sdata_in | input | 1 | Serial data from the slave |
| sclk_out | output | 1 | Generated shift clock |
| rd_strobe | input | 1 | Pops one FIFO entry per asserted cycle |
| rd_data | output | 8 | Oldest unread character, or the last one read when empty |
| rx_pending | output | 1 | High while unread characters remain |
| overrun | output | 1 | Overrun error flag (read-only) |
| single_req | output | 1 | Single-character request still pending |

## Verification
Every output is a register or a selection between registers, so each result appears one system clock after the rising edge where its cause was sampled. The clock level changes on the edge that ends a half period. FIFO entry, `rx_pending`, `overrun` and `single_req` change one cycle after the eighth falling edge. Overrun clearing and popping take effect one cycle after the read or the `cont_en` drop. The bench's behavioural model advances on each rising edge, and its prediction is compared with the outputs at the following falling edge, halfway through the cycle. Directed checks sample on falling edges a known number of cycles after each stimulus.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_CHAR_W = 8;
  localparam int unsigned SRX_DIV_W  = 8;
  localparam int unsigned SRX_BIT_W  = $clog2(SRX_CHAR_W);

  typedef logic [SRX_CHAR_W-1:0] char_t;
  typedef logic [SRX_DIV_W-1:0]  half_t;
  typedef logic [SRX_BIT_W-1:0]  bitidx_t;

  // last count value of a half period; a zero setting behaves like one
  function automatic half_t srx_last_tick(half_t h);
    return (h == '0) ? '0 : half_t'(h - half_t'(1));
  endfunction

  // new bits enter at the top so the first bit ends at position 0
  function automatic char_t srx_shift_in(char_t sh, logic b);
    return {b, sh[SRX_CHAR_W-1:1]};
  endfunction

  function automatic logic srx_last_bit(bitidx_t idx);
    return idx == bitidx_t'(SRX_CHAR_W - 1);
  endfunction
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen
  import srx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  half_t half_div,
  output logic  sclk,
  output logic  fall_evt
);
  half_t cnt_q;
  logic  sclk_q;
  logic  hit;

  assign hit      = (cnt_q == srx_last_tick(half_div));
  assign fall_evt = run && hit && sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= half_t'(cnt_q + half_t'(1));
    end
  end

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q); // R1
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hit) |=> $stable(sclk_q)); // R1
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  fall_evt,
  input  logic  sdata_in,
  output logic  char_done,
  output char_t new_char
);
  char_t   sh_q;
  bitidx_t idx_q;

  assign new_char  = srx_shift_in(sh_q, sdata_in);
  assign char_done = fall_evt && srx_last_bit(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (!run) begin
      idx_q <= '0;
    end else if (fall_evt) begin
      sh_q  <= new_char;
      idx_q <= srx_last_bit(idx_q) ? '0 : bitidx_t'(idx_q + bitidx_t'(1));
    end
  end

  AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (idx_q == '0)); // R4
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  char_t         din,
  output char_t         head,
  output logic [CW-1:0] count
);
  char_t         mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] advance(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + PW'(1));
  endfunction

  assign head  = mem[rd_q];
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem[wr_q] <= din;
        wr_q      <= advance(wr_q);
      end
      if (pop) rd_q <= advance(rd_q);
      if (push && !pop)      cnt_q <= CW'(cnt_q + CW'(1));
      else if (pop && !push) cnt_q <= CW'(cnt_q - CW'(1));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R9
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (cnt_q < CW'(DEPTH) || pop)); // R9
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R8
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import srx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 2,
  localparam int unsigned FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  port_en,
  input  logic                  single_set,
  input  logic                  cont_en,
  input  logic [SRX_DIV_W-1:0]  half_div,
  input  logic                  sdata_in,
  output logic                  sclk_out,
  input  logic                  rd_strobe,
  output logic [SRX_CHAR_W-1:0] rd_data,
  output logic                  rx_pending,
  output logic                  overrun,
  output logic                  single_req
);
  logic           single_q, ovr_q, ovr_cont_q;
  char_t          last_q;
  logic           run, fall_evt, char_done;
  char_t          new_char, fifo_head;
  logic [FCW-1:0] fifo_count;
  logic           pop, accept, push, ovr_set, ovr_clr;

  // clocking is allowed only with a request pending and no error
  assign run     = port_en && !ovr_q && (single_q || cont_en);
  assign pop     = port_en && rd_strobe && (fifo_count != '0);
  assign accept  = (fifo_count < FCW'(FIFO_DEPTH)) || pop;
  assign push    = port_en && char_done && accept;
  assign ovr_set = port_en && char_done && !accept;
  // the clearing rule follows the mode latched when the error occurred
  assign ovr_clr = ovr_q && (ovr_cont_q ? !cont_en : rd_strobe);

  srx_clkgen u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_div (half_div),
    .sclk     (sclk_out),
    .fall_evt (fall_evt)
  );

  srx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .fall_evt  (fall_evt),
    .sdata_in  (sdata_in),
    .char_done (char_done),
    .new_char  (new_char)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!port_en),
    .push  (push),
    .pop   (pop),
    .din   (new_char),
    .head  (fifo_head),
    .count (fifo_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q   <= 1'b0;
      ovr_q      <= 1'b0;
      ovr_cont_q <= 1'b0;
      last_q     <= '0;
    end else if (!port_en) begin
      single_q   <= 1'b0;
      ovr_q      <= 1'b0;
      ovr_cont_q <= 1'b0;
      last_q     <= '0;
    end else begin
      if (single_set)     single_q <= 1'b1;
      else if (char_done) single_q <= 1'b0;
      if (ovr_set) begin
        ovr_q      <= 1'b1;
        ovr_cont_q <= cont_en;
      end else if (ovr_clr) begin
        ovr_q      <= 1'b0;
        ovr_cont_q <= 1'b0;
      end
      if (pop) last_q <= fifo_head;
    end
  end

  assign rd_data    = (fifo_count != '0) ? fifo_head : last_q;
  assign rx_pending = (fifo_count != '0);
  assign overrun    = ovr_q;
  assign single_req = single_q;

  AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && char_done && !single_set) |=> !single_q); // R2
  AST_CHAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && char_done && fifo_count == '0) |=> rx_pending); // R6
  AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && fifo_count == FCW'(1)) |=> !rx_pending); // R7
  AST_OVR_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> !char_done); // R9
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ovr_q && !rd_strobe) |=> $stable(fifo_count)); // R9
  AST_SINGLE_OVR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ovr_q && !ovr_cont_q && rd_strobe) |=> !ovr_q); // R10
  AST_CONT_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ovr_q && ovr_cont_q && cont_en) |=> ovr_q); // R11
  AST_CONT_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ovr_q && ovr_cont_q && !cont_en) |=> !ovr_q); // R11
  AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!ovr_q && !single_q && !rx_pending && !sclk_out)); // R12
endmodule

// File: tb/tb_sync_master_rx.sv
module tb_sync_master_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, single_set = 1'b0, cont_en = 1'b0, rd_strobe = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic       sdata_in = 1'b0;
  logic       sclk_out, rx_pending, overrun, single_req;
  logic [7:0] rd_data;

  always #4 clk = ~clk; // 125 MHz

  sync_master_rx dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_set(single_set),
    .cont_en(cont_en), .half_div(half_div), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .rx_pending(rx_pending), .overrun(overrun), .single_req(single_req)
  );

  int checks = 0, errors = 0;
  bit ended = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // serial data source: pseudo-random bit changed each falling system edge
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sdata_in <= lfsr[0];
  end

  // rising shift-clock edge counter
  int  rises = 0;
  bit  prev_sclk = 0;
  always @(posedge clk) begin
    if (sclk_out && !prev_sclk) rises++;
    prev_sclk = sclk_out;
  end

  // behavioural reference model
  int m_q[$];
  int m_last, m_char, m_cnt, m_bits, m_h;
  bit m_sclk, m_single, m_ovr, m_ovr_cont, m_run, m_done, m_clr;

  always @(posedge clk) begin
    if (!rst_n || !port_en) begin
      m_sclk = 0; m_cnt = 0; m_bits = 0; m_char = 0; m_single = 0;
      m_ovr = 0; m_ovr_cont = 0; m_last = 0; m_q.delete();
    end else begin
      m_h    = (half_div == 0) ? 1 : int'(half_div);
      m_run  = !m_ovr && (m_single || cont_en);
      m_done = 0;
      m_clr  = m_ovr && (m_ovr_cont ? !cont_en : rd_strobe);
      if (m_run) begin
        m_cnt++;
        if (m_cnt == m_h) begin
          m_cnt = 0;
          if (m_sclk) begin
            m_char = ((m_char >> 1) | (int'(sdata_in) << 7)) & 255;
            m_bits++;
            if (m_bits == 8) begin m_done = 1; m_bits = 0; end
          end
          m_sclk = !m_sclk;
        end
      end else begin
        m_cnt = 0; m_sclk = 0; m_bits = 0;
      end
      if (rd_strobe && m_q.size() > 0) m_last = m_q.pop_front();
      if (m_done) begin
        if (m_q.size() < 2) m_q.push_back(m_char);
        else begin m_ovr = 1; m_ovr_cont = cont_en; end
      end
      if (m_clr) begin m_ovr = 0; m_ovr_cont = 0; end
      if (single_set) m_single = 1;
      else if (m_done) m_single = 0;
    end
  end

  int m_exp_data;
  always @(negedge clk) begin
    if (rst_n) begin
      m_exp_data = (m_q.size() > 0) ? m_q[0] : m_last;
      chk(sclk_out == m_sclk, "R1 sclk_out", sclk_out, m_sclk);
      chk(rd_data == m_exp_data[7:0], "R7 rd_data", rd_data, m_exp_data);
      chk(rx_pending == (m_q.size() > 0), "R6 rx_pending", rx_pending, m_q.size() > 0);
      chk(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
      chk(single_req == m_single, "R2 single_req", single_req, m_single);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_single();
    single_set = 1; tick(1); single_set = 0;
  endtask

  task automatic pulse_read();
    rd_strobe = 1; tick(1); rd_strobe = 0;
  endtask

  task automatic wait_single_done();
    for (int k = 0; k < 1000 && single_req; k++) tick(1);
  endtask

  task automatic wait_overrun();
    for (int k = 0; k < 2000 && !overrun; k++) tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  int c0, c1, v, r0;
  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // reset state (R12)
    chk(sclk_out == 0, "R12 reset sclk", sclk_out, 0);
    chk(rx_pending == 0, "R12 reset pending", rx_pending, 0);
    chk(overrun == 0, "R12 reset overrun", overrun, 0);
    chk(rd_data == 0, "R12 reset rd_data", rd_data, 0);
    port_en = 1;
    tick(2);

    // single character, half period 2 (R1, R2, R6)
    half_div = 8'd2; rises = 0;
    pulse_single();
    chk(single_req == 1, "R2 request held", single_req, 1);
    wait_single_done();
    tick(3);
    chk(rises == 8, "R1 eight pulses", rises, 8);
    chk(single_req == 0, "R2 self clear", single_req, 0);
    chk(rx_pending == 1, "R6 char landed", rx_pending, 1);
    chk(sclk_out == 0, "R1 idle low", sclk_out, 0);

    // second single with half_div 0 acting as 1 (R1)
    half_div = 8'd0; rises = 0;
    pulse_single();
    wait_single_done();
    tick(3);
    chk(rises == 8, "R1 zero divider", rises, 8);
    c0 = m_q[0]; c1 = m_q[1];
    chk(rd_data == c0[7:0], "R7 oldest first", rd_data, c0);
    // back-to-back pops (R7)
    rd_strobe = 1; tick(1);
    chk(rd_data == c1[7:0], "R7 second entry", rd_data, c1);
    tick(1); rd_strobe = 0;
    chk(rx_pending == 0, "R7 drained", rx_pending, 0);
    v = rd_data;
    // empty read (R8)
    pulse_read();
    chk(rd_data == v[7:0], "R8 empty read keeps", rd_data, v);
    chk(rx_pending == 0, "R8 empty read state", rx_pending, 0);

    // mid-character abort (R4)
    half_div = 8'd1;
    cont_en = 1; tick(7);
    cont_en = 0; tick(1);
    chk(sclk_out == 0, "R4 clock stops", sclk_out, 0);
    tick(3);
    chk(rx_pending == 0, "R4 partial discarded", rx_pending, 0);
    rises = 0;
    pulse_single();
    wait_single_done();
    tick(2);
    chk(rises == 8, "R4 restart from bit 0", rises, 8);
    chk(rx_pending == 1, "R4 fresh char", rx_pending, 1);
    pulse_read();

    // both requests, continuous overrun (R3, R5, R9, R11)
    cont_en = 1; pulse_single();
    wait_single_done();
    r0 = rises;
    chk(single_req == 0, "R5 single cleared", single_req, 0);
    tick(6);
    chk(rises > r0, "R5 continuous goes on", rises, r0 + 1);
    wait_overrun();
    chk(overrun == 1, "R3 overrun after stream", overrun, 1);
    tick(2);
    r0 = rises;
    chk(sclk_out == 0, "R9 clock stopped", sclk_out, 0);
    c0 = rd_data;
    pulse_read();
    chk(overrun == 1, "R11 read ignored", overrun, 1);
    tick(10);
    chk(rises == r0, "R9 no clocks while error", rises, r0);
    chk(rx_pending == 1, "R9 kept entry", rx_pending, 1);
    cont_en = 0; tick(1);
    chk(overrun == 0, "R11 cleared by cont drop", overrun, 0);
    pulse_read();
    chk(rx_pending == 0, "R7 emptied", rx_pending, 0);

    // single-mode overrun (R9, R10)
    pulse_single(); wait_single_done(); tick(1);
    c0 = rd_data;
    pulse_single(); wait_single_done(); tick(1);
    c1 = m_q[1];
    pulse_single(); wait_single_done(); tick(1);
    chk(overrun == 1, "R9 third char overruns", overrun, 1);
    chk(rd_data == c0[7:0], "R9 head kept", rd_data, c0);
    pulse_read();
    chk(overrun == 0, "R10 read clears", overrun, 0);
    chk(rd_data == c1[7:0], "R10 read popped", rd_data, c1);

    // port disable (R12)
    port_en = 0; tick(1);
    single_set = 1; tick(1); single_set = 0; tick(1);
    chk(rx_pending == 0, "R12 fifo flushed", rx_pending, 0);
    chk(rd_data == 0, "R12 rd_data zero", rd_data, 0);
    chk(single_req == 0, "R12 request ignored", single_req, 0);
    chk(overrun == 0, "R12 overrun clear", overrun, 0);
    port_en = 1; rises = 0; tick(20);
    chk(rises == 0, "R12 no clock after enable", rises, 0);

    finish_run();
  end
endmodule